// File: doc/BRIEF.md
# Video Line Store Controller

This block manages a chain of eight line memories that together present a vertical window of pixels. The current pixel and eight delayed lines come out side by side. Each delayed tap carries the pixel that was written at the same horizontal position one, two, and so on up to eight line-writes earlier. The memories fall into two groups of four. The first group always takes the incoming pixel. The second group takes either the output of the first group or a byte from an external port. When the second group is chained to the first, that port becomes an output carrying the fourth tap.

A per-line write policy decides how many pixels go into the memories on each line, under one of three modes:
- **Sync mode** writes pixels until the horizontal sync.
- **Count mode** writes only a programmed number of pixels and drops the rest up to the sync.
- **Frame-store mode** wraps after a fixed line length on its own and ignores the sync.

All configuration inputs are sampled only at a line boundary, so a change never splits a line. Two further options are available:
- An optional four-stage alignment pipeline delays the pixel stream for video whose first valid pixel arrives one period late.
- A bypass removes the first memory of the second group, under the conditions listed below.

Top module: `line_store_ctrl`

## Requirements
- R1: While reset is held and after it is released, `taps_vld` is 0, `taps` is all zero, `ext_out` is 0 and `ext_oe` is 0. The external port is selected as the second-group source until the first line boundary. The active mode is idle.
- R2: Sync mode (`cfg_mode` = 2'b00). Each cycle with `pix_vld`=1 and `hsync`=0 writes one pixel at the next position, starting from 0. A cycle with `hsync`=1 is a line boundary and returns the position to 0; a pixel offered in that cycle is discarded. Pixels beyond position DEPTH-1 are discarded.
- R3: Count mode (`cfg_mode` = 2'b01). Only the first `cfg_count` valid pixels of a line are written. Later pixels up to the `hsync` are discarded, and `hsync` is the line boundary.
- R4: Frame-store mode (`cfg_mode` = 2'b10). Every valid pixel is written, even in a cycle with `hsync`=1. The line boundary falls on the write at position `cfg_flen`-1, where a value of 0 means DEPTH. `hsync` has no effect.
- R5: Mode 2'b11 is idle. No pixel is written, `taps_vld` stays 0, and `hsync` is still a line boundary.
- R6: `cfg_mode`, `cfg_count`, `cfg_flen`, `cfg_g2_ext`, `cfg_bypass`, `cfg_wide` and `cfg_nlines` are taken into use only in the cycle of a line boundary. The new values govern the pixels that follow that boundary.
- R7: One cycle after a write, `taps[7:0]` holds the written pixel. Byte k of `taps` (bits 8k+7..8k, k = 1..4) holds the value written at the same position k writes earlier.
- R8: When the active `cfg_g2_ext` is 1, the second group is fed from `ext_in`, sampled in the write cycle. When it is 0, the group is fed from tap 4, `ext_oe` is 1, and `ext_out` shows tap 4 of the most recent write. Without bypass, tap 4+j (j = 1..4) is the second-group source value j writes earlier.
- R9: The bypass is effective only when all of these hold for the active values: `cfg_bypass`=1, `cfg_wide`=0 (8-bit pixel mode), `cfg_nlines` > 4 and `cfg_g2_ext`=1. When it is effective, tap 5 is the current second-group source and tap 4+j is that source j-1 writes earlier.
- R10: When any of the R9 conditions fails, `cfg_bypass` has no effect on any tap. In particular it has no effect while the external port is an output (`cfg_g2_ext`=0).
- R11: With `skew_en`=1, `pix_vld`, `pix_dat` and `hsync` reach the line logic four cycles later than with `skew_en`=0. `ext_in` is not delayed.
- R12: A line counts as filled when a line boundary occurs after at least one write in that line; the count saturates at 8. `taps_vld` pulses one cycle after each write made while the filled count is at least the active `cfg_nlines`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_vld | input | 1 | Pixel qualifier |
| pix_dat | input | 8 | Incoming pixel |
| hsync | input | 1 | Horizontal sync pulse (line end) |
| skew_en | input | 1 | Enable four-stage input alignment |
| cfg_mode | input | 2 | Line-length mode: 00 sync, 01 count, 10 frame store, 11 idle |
| cfg_count | input | 8 | Pixels written per line in count mode |
| cfg_flen | input | 8 | Line length in frame-store mode (0 = DEPTH) |
| cfg_g2_ext | input | 1 | 1: second group fed from ext_in; 0: chained |
| cfg_bypass | input | 1 | Request bypass of the first second-group memory |
| cfg_wide | input | 1 | 1: 16-bit pixel mode (disables bypass) |
| cfg_nlines | input | 4 | Lines in use; sets fill threshold |
| ext_in | input | 8 | External second-group source |
| ext_out | output | 8 | Tap 4 when the port is an output |
| ext_oe | output | 1 | External port drives out |
| taps | output | 72 | Nine taps, tap k in bits 8k+7..8k |
| taps_vld | output | 1 | Window valid strobe |

## Verification
The case that matters most is a frame-store line wrap landing in the same cycle as a boundary-time configuration switch, with a sync pulse arriving at the same moment. That one write must land in the memory, end the line, bump the fill count and take in a new mode, while the sync pulse is dropped. The bench provokes this in three ways:
- It pulses `hsync` together with valid pixels in frame-store mode.
- It changes the mode and the line length in mid-line.
- It flips the bypass and source selections between lines.

A behavioural model then predicts every tap and strobe, and the result is judged by comparing the design against that model on every clock.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam int PIX_W = 8;

    typedef enum logic [1:0] {
        MD_SYNC  = 2'b00,
        MD_COUNT = 2'b01,
        MD_FRAME = 2'b10,
        MD_IDLE  = 2'b11
    } lmode_e;

    typedef struct packed {
        logic             vld;
        logic             hs;
        logic [PIX_W-1:0] dat;
    } pix_s;

    typedef struct packed {
        lmode_e mode;
        logic   g2_ext;
        logic   byp;
        logic   wide;
    } lcfg_s;

    function automatic logic bypass_ok(input lcfg_s c, input logic above_grp);
        return c.byp & ~c.wide & above_grp & c.g2_ext;
    endfunction

endpackage

// File: rtl/lsc_skew.sv
module lsc_skew
    import lsc_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  pix_s din,
    output pix_s dout
);

    pix_s pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout = en ? pipe[STAGES-1] : din;

endmodule

// File: rtl/lsc_ctrl.sv
module lsc_ctrl
    import lsc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int N_DLY  = 8,
    parameter int GRP1   = 4,
    localparam int DEPTH = 2 ** ADDR_W,
    localparam int CW    = ADDR_W + 1,
    localparam int NLW   = $clog2(N_DLY + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld,
    input  logic              hs,
    input  logic [1:0]        cfg_mode,
    input  logic [ADDR_W-1:0] cfg_count,
    input  logic [ADDR_W-1:0] cfg_flen,
    input  logic              cfg_g2_ext,
    input  logic              cfg_bypass,
    input  logic              cfg_wide,
    input  logic [NLW-1:0]    cfg_nlines,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic              g2_ext,
    output logic              byp_eff,
    output logic              ready
);

    logic [CW-1:0]     pos_q;
    lcfg_s             cfg_q;
    logic [ADDR_W-1:0] lim_q;
    logic [ADDR_W-1:0] flen_q;
    logic [NLW-1:0]    nl_q;
    logic [NLW-1:0]    filled_q;
    logic              wrote_q;
    logic              bnd;

    always_comb begin
        we  = 1'b0;
        bnd = 1'b0;
        case (cfg_q.mode)
            MD_SYNC: begin
                if (hs) bnd = 1'b1;
                else if (vld && pos_q < CW'(DEPTH)) we = 1'b1;
            end
            MD_COUNT: begin
                if (hs) bnd = 1'b1;
                else if (vld && pos_q < {1'b0, lim_q}) we = 1'b1;
            end
            MD_FRAME: begin
                if (vld) begin
                    we  = 1'b1;
                    bnd = (pos_q[ADDR_W-1:0] == flen_q - ADDR_W'(1));
                end
            end
            default: bnd = hs;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            cfg_q    <= '{mode: MD_IDLE, g2_ext: 1'b1, byp: 1'b0, wide: 1'b0};
            lim_q    <= '0;
            flen_q   <= '0;
            nl_q     <= NLW'(N_DLY);
            filled_q <= '0;
            wrote_q  <= 1'b0;
        end else if (bnd) begin
            pos_q    <= '0;
            cfg_q    <= '{mode: lmode_e'(cfg_mode), g2_ext: cfg_g2_ext,
                          byp: cfg_bypass, wide: cfg_wide};
            lim_q    <= cfg_count;
            flen_q   <= cfg_flen;
            nl_q     <= cfg_nlines;
            wrote_q  <= 1'b0;
            if ((wrote_q || we) && filled_q != NLW'(N_DLY))
                filled_q <= filled_q + NLW'(1);
        end else if (we) begin
            pos_q   <= pos_q + CW'(1);
            wrote_q <= 1'b1;
        end
    end

    assign addr    = pos_q[ADDR_W-1:0];
    assign g2_ext  = cfg_q.g2_ext;
    assign byp_eff = bypass_ok(cfg_q, nl_q > NLW'(GRP1));
    assign ready   = filled_q >= nl_q;

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bnd |=> $stable(cfg_q));

    // R3
    count_lim_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MD_COUNT) |-> (pos_q <= {1'b0, lim_q}));

    // R4
    frame_len_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MD_FRAME && flen_q != '0) |-> (pos_q < {1'b0, flen_q}));

    // R2
    sync_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MD_SYNC) |-> (pos_q <= CW'(DEPTH)));

    // R12
    fill_mono_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (filled_q >= $past(filled_q)));

endmodule

// File: rtl/lsc_lines.sv
module lsc_lines
    import lsc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int N_DLY  = 8,
    parameter int GRP1   = 4,
    localparam int DEPTH = 2 ** ADDR_W,
    localparam int NTAP  = N_DLY + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [PIX_W-1:0]      pix,
    input  logic [PIX_W-1:0]      ext_in,
    input  logic                  g2_ext,
    input  logic                  byp_eff,
    input  logic                  ready,
    output logic [NTAP*PIX_W-1:0] taps,
    output logic [PIX_W-1:0]      tap_grp1,
    output logic                  taps_vld
);

    logic [PIX_W-1:0] rd     [N_DLY];
    logic [PIX_W-1:0] wr     [N_DLY];
    logic [PIX_W-1:0] tap    [NTAP];
    logic [PIX_W-1:0] taps_r [NTAP];
    logic [PIX_W-1:0] src2;

    assign src2   = g2_ext ? ext_in : rd[GRP1-1];
    assign tap[0] = pix;

    for (genvar k = 0; k < N_DLY; k++) begin : g_line
        logic [PIX_W-1:0] mem [DEPTH];

        if (k == 0) begin : g_in
            assign wr[k] = pix;
        end else if (k == GRP1) begin : g_src
            assign wr[k] = src2;
        end else if (k == GRP1 + 1) begin : g_skip
            assign wr[k] = byp_eff ? src2 : rd[k-1];
        end else begin : g_chain
            assign wr[k] = rd[k-1];
        end

        always_ff @(posedge clk) begin
            if (we) mem[addr] <= wr[k];
        end

        assign rd[k] = mem[addr];

        if (k == GRP1) begin : g_tap_byp
            assign tap[k+1] = byp_eff ? src2 : rd[k];
        end else begin : g_tap
            assign tap[k+1] = rd[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            taps_vld <= 1'b0;
            for (int i = 0; i < NTAP; i++) taps_r[i] <= '0;
        end else begin
            taps_vld <= we & ready;
            if (we) begin
                for (int i = 0; i < NTAP; i++) taps_r[i] <= tap[i];
            end
        end
    end

    for (genvar i = 0; i < NTAP; i++) begin : g_flat
        assign taps[i*PIX_W +: PIX_W] = taps_r[i];
    end

    assign tap_grp1 = taps_r[GRP1];

    // R12
    vld_src_chk: assert property (@(posedge clk) disable iff (rst)
        taps_vld |-> $past(we));

    // R7
    tap0_chk: assert property (@(posedge clk) disable iff (rst)
        taps_vld |-> (taps_r[0] == $past(pix)));

endmodule

// File: rtl/line_store_ctrl.sv
module line_store_ctrl
    import lsc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int N_DLY  = 8,
    parameter int GRP1   = 4,
    parameter int SKEW   = 4,
    localparam int NLW   = $clog2(N_DLY + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pix_vld,
    input  logic [PIX_W-1:0]             pix_dat,
    input  logic                         hsync,
    input  logic                         skew_en,
    input  logic [1:0]                   cfg_mode,
    input  logic [ADDR_W-1:0]            cfg_count,
    input  logic [ADDR_W-1:0]            cfg_flen,
    input  logic                         cfg_g2_ext,
    input  logic                         cfg_bypass,
    input  logic                         cfg_wide,
    input  logic [NLW-1:0]               cfg_nlines,
    input  logic [PIX_W-1:0]             ext_in,
    output logic [PIX_W-1:0]             ext_out,
    output logic                         ext_oe,
    output logic [(N_DLY+1)*PIX_W-1:0]   taps,
    output logic                         taps_vld
);

    pix_s              raw_px;
    pix_s              al_px;
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic              g2_ext;
    logic              byp_eff;
    logic              ready;

    assign raw_px = '{vld: pix_vld, hs: hsync, dat: pix_dat};

    lsc_skew #(.STAGES(SKEW)) u_skew (
        .clk  (clk),
        .rst  (rst),
        .en   (skew_en),
        .din  (raw_px),
        .dout (al_px)
    );

    lsc_ctrl #(.ADDR_W(ADDR_W), .N_DLY(N_DLY), .GRP1(GRP1)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .vld        (al_px.vld),
        .hs         (al_px.hs),
        .cfg_mode   (cfg_mode),
        .cfg_count  (cfg_count),
        .cfg_flen   (cfg_flen),
        .cfg_g2_ext (cfg_g2_ext),
        .cfg_bypass (cfg_bypass),
        .cfg_wide   (cfg_wide),
        .cfg_nlines (cfg_nlines),
        .we         (we),
        .addr       (addr),
        .g2_ext     (g2_ext),
        .byp_eff    (byp_eff),
        .ready      (ready)
    );

    lsc_lines #(.ADDR_W(ADDR_W), .N_DLY(N_DLY), .GRP1(GRP1)) u_lines (
        .clk      (clk),
        .rst      (rst),
        .we       (we),
        .addr     (addr),
        .pix      (al_px.dat),
        .ext_in   (ext_in),
        .g2_ext   (g2_ext),
        .byp_eff  (byp_eff),
        .ready    (ready),
        .taps     (taps),
        .tap_grp1 (ext_out),
        .taps_vld (taps_vld)
    );

    assign ext_oe = ~g2_ext;

endmodule

// File: tb/sim_line_store_ctrl.sv
module sim_line_store_ctrl;

    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_vld = 1'b0;
    logic [7:0] pix_dat = '0;
    logic       hsync = 1'b0;
    logic       skew_en = 1'b0;
    logic [1:0] cfg_mode = 2'b11;
    logic [7:0] cfg_count = '0;
    logic [7:0] cfg_flen = '0;
    logic       cfg_g2_ext = 1'b1;
    logic       cfg_bypass = 1'b0;
    logic       cfg_wide = 1'b0;
    logic [3:0] cfg_nlines = 4'd8;
    logic [7:0] ext_in = '0;
    logic [7:0] ext_out;
    logic       ext_oe;
    logic [71:0] taps;
    logic       taps_vld;

    line_store_ctrl u0 (
        .clk(clk), .rst(rst), .pix_vld(pix_vld), .pix_dat(pix_dat), .hsync(hsync),
        .skew_en(skew_en), .cfg_mode(cfg_mode), .cfg_count(cfg_count),
        .cfg_flen(cfg_flen), .cfg_g2_ext(cfg_g2_ext), .cfg_bypass(cfg_bypass),
        .cfg_wide(cfg_wide), .cfg_nlines(cfg_nlines), .ext_in(ext_in),
        .ext_out(ext_out), .ext_oe(ext_oe), .taps(taps), .taps_vld(taps_vld)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int cyc_cnt = 0;
    string tag = "R1";

    // bench-side configuration requests, copied to ports each cycle
    int b_mode = 3, b_cnt = 0, b_flen = 0, b_g2 = 1, b_byp = 0, b_wide = 0, b_nl = 8, b_skew = 0;

    // reference model state
    int a_mode = 3, a_cnt = 0, a_flen = 0, a_g2 = 1, a_byp = 0, a_wide = 0, a_nl = 8;
    int pos = 0, filled = 0;
    bit wrote = 0;
    int sv[4], sh[4], sd[4];
    int hist_a [DEPTH][$];
    int hist_b [DEPTH][$];
    bit exp_vld = 0;
    int exp_tap[9];
    int exp_eo = 0, exp_eout = 0;

    function automatic int get_back(input int q[$], input int n);
        if (q.size() >= n) return q[q.size() - n];
        return -1;
    endfunction

    function automatic int byp_on();
        return (a_byp != 0 && a_wide == 0 && a_nl > 4 && a_g2 != 0) ? 1 : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc_cnt);
        end
    endtask

    task automatic model_step();
        bit v, h, we, bnd;
        int d, be, p, src, n, last, old_be;
        int t[9];
        v = b_skew ? sv[3][0] : pix_vld;
        h = b_skew ? sh[3][0] : hsync;
        d = b_skew ? sd[3] : int'(pix_dat);
        for (int i = 3; i > 0; i--) begin
            sv[i] = sv[i-1]; sh[i] = sh[i-1]; sd[i] = sd[i-1];
        end
        sv[0] = pix_vld; sh[0] = hsync; sd[0] = pix_dat;
        we = 0; bnd = 0;
        case (a_mode)
            0: if (h) bnd = 1; else if (v && pos < DEPTH) we = 1;
            1: if (h) bnd = 1; else if (v && pos < a_cnt) we = 1;
            2: if (v) begin
                   we = 1;
                   last = (a_flen == 0) ? DEPTH - 1 : a_flen - 1;
                   bnd = (pos == last);
               end
            default: bnd = h;
        endcase
        exp_vld = we && (filled >= a_nl);
        if (we) begin
            be = byp_on();
            p = pos;
            t[0] = d;
            for (int k = 1; k <= 4; k++) t[k] = get_back(hist_a[p], k);
            src = a_g2 ? int'(ext_in) : t[4];
            for (int k = 5; k <= 8; k++) begin
                n = k - 4 - be;
                t[k] = (n == 0) ? src : get_back(hist_b[p], n);
            end
            hist_a[p].push_back(d);
            if (hist_a[p].size() > 4) void'(hist_a[p].pop_front());
            hist_b[p].push_back(src);
            if (hist_b[p].size() > 4) void'(hist_b[p].pop_front());
            for (int k = 0; k < 9; k++) exp_tap[k] = t[k];
            exp_eout = t[4];
        end
        if (bnd) begin
            old_be = byp_on();
            pos = 0;
            if ((wrote || we) && filled < 8) filled++;
            wrote = 0;
            a_mode = b_mode; a_cnt = b_cnt; a_flen = b_flen; a_g2 = b_g2;
            a_byp = b_byp; a_wide = b_wide; a_nl = b_nl;
            if (byp_on() != old_be) begin
                for (int i = 0; i < DEPTH; i++) hist_b[i].delete();
            end
        end else if (we) begin
            pos++;
            wrote = 1;
        end
        exp_eo = a_g2 ? 0 : 1;
    endtask

    task automatic compare();
        check({tag, " taps_vld"}, int'(taps_vld), int'(exp_vld));
        if (exp_vld) begin
            for (int k = 0; k < 9; k++) begin
                if (exp_tap[k] >= 0)
                    check($sformatf("%s/R7 tap%0d", tag, k), int'(taps[k*8 +: 8]), exp_tap[k]);
            end
        end
        check("R8 ext_oe", int'(ext_oe), exp_eo);
        if (exp_eout >= 0) check("R8 ext_out", int'(ext_out), exp_eout);
    endtask

    task automatic cyc(input bit v, input int d, input bit h);
        @(negedge clk);
        compare();
        pix_vld = v; pix_dat = d[7:0]; hsync = h;
        ext_in = 8'($urandom_range(0, 255));
        skew_en = b_skew[0];
        cfg_mode = b_mode[1:0]; cfg_count = b_cnt[7:0]; cfg_flen = b_flen[7:0];
        cfg_g2_ext = b_g2[0]; cfg_bypass = b_byp[0]; cfg_wide = b_wide[0];
        cfg_nlines = b_nl[3:0];
        model_step();
    endtask

    task automatic line(input int n);
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(0, 4) == 0) cyc(0, 0, 0);
            cyc(1, $urandom_range(0, 255), 0);
        end
        cyc(0, 0, 1);
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog (all R): actual=%0d cycles expected<150000", cyc_cnt);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin sv[i] = 0; sh[i] = 0; sd[i] = 0; end
        for (int k = 0; k < 9; k++) exp_tap[k] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 taps_vld", int'(taps_vld), 0);
        check("R1 taps", (taps == '0) ? 1 : 0, 1);
        check("R1 ext_oe", int'(ext_oe), 0);
        check("R1 ext_out", int'(ext_out), 0);
        rst = 1'b0;
        model_step();

        // R1: idle after reset, pixels ignored until first boundary
        cyc(1, 7, 0); cyc(1, 9, 0);
        // R12: fill the chain in sync mode
        tag = "R12";
        b_mode = 0; b_g2 = 0; b_nl = 8;
        cyc(0, 0, 1);
        for (int l = 0; l < 10; l++) line(6);

        // R2: varying lengths, pixel on hsync cycle, overlong line
        tag = "R2";
        line(3); line(8); line(5);
        cyc(1, 33, 1);
        line(6);
        for (int i = 0; i < 260; i++) cyc(1, i & 255, 0);
        cyc(0, 0, 1);
        for (int l = 0; l < 4; l++) line(7);

        // R3: count mode
        tag = "R3";
        b_mode = 1; b_cnt = 4;
        for (int l = 0; l < 8; l++) line(7);

        // R4: frame-store mode with ignored sync pulses
        tag = "R4";
        b_mode = 2; b_flen = 5;
        cyc(0, 0, 1);
        for (int i = 0; i < 60; i++) cyc(1, $urandom_range(0, 255), (i % 7) == 3);

        // R6: mid-line changes take effect only at the wrap
        tag = "R6";
        cyc(1, 11, 0); cyc(1, 12, 0);
        b_flen = 3; b_cnt = 2;
        for (int i = 0; i < 20; i++) cyc(1, $urandom_range(0, 255), 0);
        b_mode = 0;
        cyc(1, 21, 0);
        for (int i = 0; i < 6; i++) cyc(1, $urandom_range(0, 255), 0);
        cyc(0, 0, 1);
        for (int l = 0; l < 5; l++) line(5);

        // R8: external source for the second group
        tag = "R8";
        b_g2 = 1;
        for (int l = 0; l < 7; l++) line(5);

        // R9: effective bypass
        tag = "R9";
        b_byp = 1; b_nl = 8; b_wide = 0;
        for (int l = 0; l < 7; l++) line(5);

        // R10: bypass requested but not effective
        tag = "R10";
        b_wide = 1;
        for (int l = 0; l < 6; l++) line(5);
        b_wide = 0; b_nl = 4;
        for (int l = 0; l < 6; l++) line(5);
        b_nl = 8; b_g2 = 0;
        for (int l = 0; l < 6; l++) line(5);
        b_byp = 0;

        // R11: input alignment pipeline
        tag = "R11";
        cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);
        b_skew = 1;
        for (int i = 0; i < 5; i++) cyc(0, 0, 0);
        for (int l = 0; l < 7; l++) line(6);
        for (int i = 0; i < 5; i++) cyc(0, 0, 0);
        b_skew = 0;
        for (int i = 0; i < 5; i++) cyc(0, 0, 0);

        // R5: idle mode writes nothing
        tag = "R5";
        b_mode = 3;
        line(4);
        for (int l = 0; l < 4; l++) line(6);
        b_mode = 0;
        line(3);
        for (int l = 0; l < 3; l++) line(6);
        cyc(0, 0, 0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule